// File: doc/BRIEF.md
# Serial RTC Register Front End

This block is the serial slave side of a small real-time-clock register file. It holds sixteen 8-bit registers and serves them to a host over a mode-0 serial link (clock idles low, data sampled on the rising edge, changed on the falling edge). The select line is active high. The serial clock, select and data-in pins are resynchronised into the system clock domain and their edges are detected there. This suits serial clocks up to about 1 MHz against a system clock many times faster.

Every transaction opens with a command byte. Bit 7 chooses a read (1) or a write (0). Bit 4 is a marker that must be 1. Bits 3:0 give the first register address. The bytes that follow stream out of, or into, consecutive registers. The address wraps from 15 to 0, so a seven-byte burst from address 2 covers the whole time-of-day group in one transaction. Writing the value 0x58 to register 0 is a software reset: every register returns to its default. Register 2 defaults to 0x80, whose top bit tells the host that the time is not valid. Bit 5 of register 0 is the stop control and drives the `stop_o` pin.

The timekeeping, alarm and offset logic sit outside this block. They update registers through a single-cycle core write port. They learn of host writes from a one-cycle notification carrying the address and data. The serial link cannot be stalled, so this notification has a valid strobe and no ready: a consumer must accept it in the cycle it appears.

Top module: `spi_rtc_regif`

## Requirements
- R1: While the select pin is low, `spi_miso_o` is 0. Dropping select part way through a byte abandons that byte, so no register changes.
- R2: A command byte with bit 4 set starts a write when bit 7 is 0 (0x10 | addr) and a read when bit 7 is 1 (0x90 | addr). Bits 3:0 give the start address.
- R3: A command byte with bit 4 clear is ignored, and the rest of that transaction is discarded. No register changes, and `spi_miso_o` stays 0 until select goes low.
- R4: Each data byte of a burst moves to the next address, and the address wraps from 15 to 0.
- R5: A write data byte takes effect on its eighth rising serial clock edge. Each committed byte produces exactly one `host_wr_valid_o` pulse carrying its address and data.
- R6: Read data is sent MSB first. The byte for each address is loaded on the falling edge that ends the previous byte, and shifts on later falling edges.
- R7: Register 0 reads back exactly as written, and its bit 5 drives `stop_o`.
- R8: Writing 0x58 to register 0 returns all registers to their defaults (register 2 = 0x80, all others 0x00), which also clears `stop_o`.
- R9: After a hardware reset the registers hold the same defaults as after a software reset.
- R10: A core write (`core_we_i` high for one cycle) stores `core_wdata_i` at `core_addr_i`, and the host can read that value back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_cs_i | input | 1 | Serial select, active high |
| spi_sclk_i | input | 1 | Serial clock, mode 0 |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host, 0 while not selected |
| core_we_i | input | 1 | Core register write strobe |
| core_addr_i | input | ADDR_W | Core write address |
| core_wdata_i | input | DATA_W | Core write data |
| stop_o | output | 1 | Stop control, register 0 bit 5 |
| host_wr_valid_o | output | 1 | One-cycle pulse for a committed host write |
| host_wr_addr_o | output | ADDR_W | Address of the committed host write |
| host_wr_data_o | output | DATA_W | Data of the committed host write |

## Verification
Some properties are checked by assertions on every cycle:
- dropping select clears the shift state;
- a discarded transaction never writes;
- the burst address steps by one, modulo 16;
- the reset pattern restores the defaults one cycle later;
- `stop_o` follows an ordinary write to register 0;
- notification pulses never run back to back.

Other behaviour can only be shown by the bench's serial scenarios:
- the exact bit order and the falling-edge load timing of read data;
- wrap-around reads that start from every address;
- an aborted partial byte;
- the commands that are ignored.

// File: rtl/spi_rtc_pkg.sv
`timescale 1ns/1ps
package spi_rtc_pkg;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 4;
  localparam int NREG         = 1 << ADDR_W;
  localparam int CMD_RD_BIT   = 7;
  localparam int CMD_MARK_BIT = 4;
  localparam int CTRL_ADDR    = 0;
  localparam int OSC_ADDR     = 2;
  localparam int STOP_BIT     = 5;
  localparam logic [7:0] SOFT_RST_VAL = 8'h58;
  localparam logic [7:0] OSC_DEFAULT  = 8'h80;

  typedef enum logic [1:0] {
    PH_CMD     = 2'd0,
    PH_WRITE   = 2'd1,
    PH_READ    = 2'd2,
    PH_DISCARD = 2'd3
  } phase_e;

  function automatic logic [7:0] reg_default(input int idx);
    return (idx == OSC_ADDR) ? OSC_DEFAULT : 8'h00;
  endfunction
endpackage

// File: rtl/spi_rtc_sync.sv
`timescale 1ns/1ps
module spi_rtc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= g_stage[g-1].q;
      end
    end
  end
  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/spi_rtc_shifter.sv
`timescale 1ns/1ps
module spi_rtc_shifter
  import spi_rtc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sclk_s_i,
  input  logic          mosi_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          tx_msb_o
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  logic              sclk_d_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DW-2:0]     rx_q;
  logic [DW-1:0]     tx_q;
  logic [AW-1:0]     addr_q;
  phase_e            ph_q;

  logic          rise, fall, byte_done;
  logic [DW-1:0] rx_next;

  assign rise      = cs_s_i &  sclk_s_i & ~sclk_d_q;
  assign fall      = cs_s_i & ~sclk_s_i &  sclk_d_q;
  assign rx_next   = {rx_q, mosi_s_i};
  assign byte_done = rise && (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      addr_q <= '0;
      ph_q   <= PH_CMD;
    end else if (!cs_s_i) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      ph_q  <= PH_CMD;
    end else begin
      if (rise) begin
        cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
        rx_q  <= rx_next[DW-2:0];
        if (byte_done) begin
          unique case (ph_q)
            PH_CMD: begin
              if (rx_next[CMD_MARK_BIT]) begin
                ph_q   <= rx_next[CMD_RD_BIT] ? PH_READ : PH_WRITE;
                addr_q <= rx_next[AW-1:0];
              end else begin
                ph_q <= PH_DISCARD;
              end
            end
            PH_WRITE: addr_q <= addr_q + 1'b1;
            default: ;
          endcase
        end
      end
      if (fall) begin
        if (ph_q == PH_READ && cnt_q == '0) begin
          tx_q   <= rd_data_i;
          addr_q <= addr_q + 1'b1;
        end else begin
          tx_q <= {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign addr_o    = addr_q;
  assign wr_en_o   = byte_done && (ph_q == PH_WRITE);
  assign wr_data_o = rx_next;
  assign tx_msb_o  = tx_q[DW-1];

  // R1: deselect clears the shift state
  a_r1_deselect_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> (tx_q == '0) && (cnt_q == '0) && (ph_q == PH_CMD));
  // R3: a discarded transaction never writes
  a_r3_discard_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DISCARD) |-> !wr_en_o);
  // R4: write bursts step the address by one, modulo the register count
  a_r4_write_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && ph_q == PH_WRITE) |=> addr_q == AW'($past(addr_q) + 1'b1));
  // R4: read bursts step the address on each byte load
  a_r4_read_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && ph_q == PH_READ && cnt_q == '0) |=> addr_q == AW'($past(addr_q) + 1'b1));
endmodule

// File: rtl/spi_rtc_regfile.sv
`timescale 1ns/1ps
module spi_rtc_regfile
  import spi_rtc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          spi_we_i,
  input  logic [AW-1:0] spi_addr_i,
  input  logic [DW-1:0] spi_wdata_i,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          stop_o
);
  localparam int N = 1 << AW;

  logic [DW-1:0] regs_q [N];
  logic          soft_rst;

  assign soft_rst = spi_we_i && (spi_addr_i == AW'(CTRL_ADDR)) &&
                    (spi_wdata_i == DW'(SOFT_RST_VAL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= DW'(reg_default(i));
    end else if (soft_rst) begin
      for (int i = 0; i < N; i++) regs_q[i] <= DW'(reg_default(i));
    end else begin
      for (int i = 0; i < N; i++) begin
        if (spi_we_i && spi_addr_i == AW'(i))        regs_q[i] <= spi_wdata_i;
        else if (core_we_i && core_addr_i == AW'(i)) regs_q[i] <= core_wdata_i;
      end
    end
  end

  assign rd_data_o = regs_q[rd_addr_i];
  assign stop_o    = regs_q[CTRL_ADDR][STOP_BIT];

  // R8: the reset pattern restores the defaults on the next cycle
  a_r8_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (regs_q[CTRL_ADDR] == '0) && (regs_q[OSC_ADDR] == DW'(OSC_DEFAULT)) && !stop_o);
  // R7: an ordinary write to register 0 sets the stop pin from bit 5
  a_r7_stop_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_we_i && spi_addr_i == AW'(CTRL_ADDR) && !soft_rst) |=> stop_o == $past(spi_wdata_i[STOP_BIT]));
endmodule

// File: rtl/spi_rtc_regif.sv
`timescale 1ns/1ps
module spi_rtc_regif
  import spi_rtc_pkg::*;
#(
  parameter int ADDR_W_P    = ADDR_W,
  parameter int DATA_W_P    = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                spi_cs_i,
  input  logic                spi_sclk_i,
  input  logic                spi_mosi_i,
  output logic                spi_miso_o,
  input  logic                core_we_i,
  input  logic [ADDR_W_P-1:0] core_addr_i,
  input  logic [DATA_W_P-1:0] core_wdata_i,
  output logic                stop_o,
  output logic                host_wr_valid_o,
  output logic [ADDR_W_P-1:0] host_wr_addr_o,
  output logic [DATA_W_P-1:0] host_wr_data_o
);
  logic [2:0]          pins_s;
  logic [ADDR_W_P-1:0] addr;
  logic                wr_en;
  logic [DATA_W_P-1:0] wr_data;
  logic [DATA_W_P-1:0] rd_data;
  logic                tx_msb;

  spi_rtc_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({spi_cs_i, spi_sclk_i, spi_mosi_i}),
    .q_o    (pins_s)
  );

  spi_rtc_shifter #(.DW(DATA_W_P), .AW(ADDR_W_P)) shift_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (pins_s[2]),
    .sclk_s_i  (pins_s[1]),
    .mosi_s_i  (pins_s[0]),
    .rd_data_i (rd_data),
    .addr_o    (addr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .tx_msb_o  (tx_msb)
  );

  spi_rtc_regfile #(.DW(DATA_W_P), .AW(ADDR_W_P)) regs_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .spi_we_i     (wr_en),
    .spi_addr_i   (addr),
    .spi_wdata_i  (wr_data),
    .core_we_i    (core_we_i),
    .core_addr_i  (core_addr_i),
    .core_wdata_i (core_wdata_i),
    .rd_addr_i    (addr),
    .rd_data_o    (rd_data),
    .stop_o       (stop_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_wr_valid_o <= 1'b0;
      host_wr_addr_o  <= '0;
      host_wr_data_o  <= '0;
    end else begin
      host_wr_valid_o <= wr_en;
      if (wr_en) begin
        host_wr_addr_o <= addr;
        host_wr_data_o <= wr_data;
      end
    end
  end

  assign spi_miso_o = spi_cs_i & tx_msb;

  // R5: each committed byte gives a single-cycle notification
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_valid_o |=> !host_wr_valid_o);
endmodule

// File: tb/spi_rtc_regif_tb.sv
`timescale 1ns/1ps
module spi_rtc_regif_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, mosi = 1'b0;
  logic core_we = 1'b0;
  logic [3:0] core_addr = '0;
  logic [7:0] core_wdata = '0;
  logic miso, stop, hv;
  logic [3:0] ha;
  logic [7:0] hd;

  always #2.5 clk = ~clk;

  spi_rtc_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_cs_i(cs), .spi_sclk_i(sclk), .spi_mosi_i(mosi), .spi_miso_o(miso),
    .core_we_i(core_we), .core_addr_i(core_addr), .core_wdata_i(core_wdata),
    .stop_o(stop), .host_wr_valid_o(hv), .host_wr_addr_o(ha), .host_wr_data_o(hd)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0;
  logic [3:0] last_a;
  logic [7:0] last_d;
  logic [7:0] expv [16];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  bit done = 0;

  always @(negedge clk) if (hv) begin
    wr_cnt++; last_a = ha; last_d = hd;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] defv(input int a);
    return (a == 2) ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      waitc(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      waitc(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs = 1'b1; waitc(HALF);
  endtask

  task automatic cs_end();
    waitc(HALF); cs = 1'b0; waitc(2 * HALF);
  endtask

  task automatic spi_write(input int a, input int n);
    logic [7:0] d;
    cs_begin();
    spi_bits(8'h10 | 8'(a), 8, d);
    for (int k = 0; k < n; k++) spi_bits(wbuf[k], 8, d);
    cs_end();
  endtask

  task automatic spi_read(input int a, input int n);
    logic [7:0] d;
    cs_begin();
    spi_bits(8'h90 | 8'(a), 8, d);
    for (int k = 0; k < n; k++) spi_bits(8'h00, 8, rbuf[k]);
    cs_end();
  endtask

  task automatic read_all_check(input string req);
    spi_read(0, 16);
    for (int k = 0; k < 16; k++) chk(req, rbuf[k], expv[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int base;
    for (int a = 0; a < 16; a++) expv[a] = defv(a);
    waitc(5); rst_n = 1'b1; waitc(5);

    // R9 reset state, R1 idle output
    chk("R9 stop after reset", stop, 0);
    chk("R1 miso idle", miso, 0);
    chk("R5 no notify at reset", hv, 0);
    read_all_check("R9 defaults via R2 read");

    // R2/R5 single writes to addresses 1..15
    base = wr_cnt;
    for (int a = 1; a < 16; a++) begin
      wbuf[0] = pat(a); expv[a] = pat(a);
      spi_write(a, 1);
    end
    chk("R5 notify count", wr_cnt - base, 15);
    chk("R5 notify addr", last_a, 15);
    chk("R5 notify data", last_d, pat(15));

    // R7 stop bit
    wbuf[0] = 8'h20; expv[0] = 8'h20; spi_write(0, 1);
    chk("R7 stop set", stop, 1);
    spi_read(0, 1);
    chk("R7 readback", rbuf[0], 8'h20);

    // R4/R6 sweep of burst reads from every start address
    for (int s = 0; s < 16; s++) begin
      spi_read(s, 17);
      for (int k = 0; k < 17; k++) chk("R4 R6 wrap read", rbuf[k], expv[(s + k) % 16]);
    end

    // R4 seven-byte burst from address 2
    for (int k = 0; k < 7; k++) begin wbuf[k] = 8'h30 + 8'(k); expv[2 + k] = wbuf[k]; end
    spi_write(2, 7);
    spi_read(2, 7);
    for (int k = 0; k < 7; k++) chk("R4 time burst", rbuf[k], expv[2 + k]);

    // R4 write wrap 14,15,0,1
    base = wr_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h48; wbuf[3] = 8'h33;
    expv[14] = 8'h11; expv[15] = 8'h22; expv[0] = 8'h48; expv[1] = 8'h33;
    spi_write(14, 4);
    chk("R5 burst notify count", wr_cnt - base, 4);
    chk("R4 last wrapped addr", last_a, 1);
    chk("R7 stop cleared by 0x48", stop, 0);
    read_all_check("R4 R7 after wrap write");

    // R3 marker clear: write-style and read-style commands ignored
    base = wr_cnt;
    cs_begin();
    spi_bits(8'h05, 8, d);
    spi_bits(8'hAA, 8, d); spi_bits(8'h58, 8, d);
    cs_end();
    chk("R3 no notify", wr_cnt - base, 0);
    cs_begin();
    spi_bits(8'h82, 8, d);
    spi_bits(8'h00, 8, d); chk("R3 miso silent", d, 0);
    spi_bits(8'h00, 8, d); chk("R3 miso silent 2", d, 0);
    cs_end();
    read_all_check("R3 registers unchanged");

    // R10 core write
    core_addr = 4'd3; core_wdata = 8'hC3; core_we = 1'b1;
    waitc(1); core_we = 1'b0; expv[3] = 8'hC3;
    waitc(2);
    spi_read(3, 1);
    chk("R10 core write readback", rbuf[0], 8'hC3);

    // R1 aborted partial byte
    base = wr_cnt;
    cs_begin();
    spi_bits(8'h15, 8, d);
    spi_bits(8'hFF, 4, d);
    cs_end();
    chk("R1 abort no notify", wr_cnt - base, 0);
    spi_read(5, 1);
    chk("R1 abort reg unchanged", rbuf[0], expv[5]);

    // R6 first read bit present before first rise, R1 miso drops with select
    cs_begin();
    spi_bits(8'h93, 8, d);
    waitc(HALF);
    chk("R6 MSB loaded after command", miso, 1);
    cs = 1'b0; #1;
    chk("R1 miso low when deselected", miso, 0);
    waitc(2 * HALF);

    // R8 software reset
    wbuf[0] = 8'h20; spi_write(0, 1);
    chk("R7 stop before soft reset", stop, 1);
    wbuf[0] = 8'h58; spi_write(0, 1);
    for (int a = 0; a < 16; a++) expv[a] = defv(a);
    chk("R8 stop cleared", stop, 0);
    read_all_check("R8 soft reset defaults");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule